// File: doc/BRIEF.md
# Burst Command Downsizer

This block sits on one AXI address channel, read or write, between a wide slave-side port and a narrower master-side port. It takes one burst command at a time and rewrites it as one or more commands whose beats match the narrow data width. INCR, WRAP and FIXED bursts are handled. Every output command respects the per-burst beat limit: 256 beats when the block is set up for AXI4 and 16 beats when it is set up for AXI3.

A command is accepted through a valid/ready handshake. The block then drops its input ready and issues the generated commands in order through a second valid/ready handshake. Each output command carries a flag marking the final command produced from its input, so that logic further down can merge the responses. Data beats, responses and IDs are handled elsewhere.

Top module: `dnz_cmd_split`

## Requirements
- R1: When the ratio ceil(2^SIZE / master byte width) is 1, exactly one command is issued, and its address, length, size, burst and lock equal the input's.
- R2: An INCR burst (burst encoding 01; the reserved encoding 11 is treated the same way) with ratio above 1 and a converted beat count (LEN+1)*ratio no greater than the limit gives one INCR command. It keeps the input address and lock and has length (LEN+1)*ratio-1-adj, where adj = (ADDR & (2^SIZE-1) & ~(masterBytes-1)) / masterBytes.
- R3: An INCR burst whose converted beat count exceeds the limit gives ceil(count/limit) commands, all with lock 0. The first command starts at ADDR with length limit-adj-1. Middle commands have length limit-1. The last has length (count-1) mod limit. Command i (counting from 1) for i>1 starts at (ADDR & ~(2^SIZE-1)) + (i-1)*limit*masterBytes.
- R4: A WRAP burst (encoding 10) with ratio above 1 and a converted beat count of 16 or fewer gives one WRAP command. It keeps the input address and lock and has length (LEN+1)*ratio-1.
- R5: A WRAP burst with a converted count above 16 becomes INCR with lock 0. If ADDR is aligned to the total burst size B = (LEN+1)*2^SIZE, one command is issued at ADDR with length count-1. Otherwise two commands are issued. The first is at ADDR with length (B - (ADDR mod B))/masterBytes - 1. The second is at ADDR & ~(B-1) with length (ADDR mod B)/masterBytes - 1.
- R6: A FIXED burst (encoding 00) with ratio above 1 gives LEN+1 INCR commands. Each is at the input address with length ratio-adj-1 and lock 0.
- R7: Whenever the ratio exceeds 1, every output command has size log2(masterBytes).
- R8: The last-command flag is high on exactly the final command generated from each input, and no command follows it before the next input is accepted.
- R9: Input ready is low from the cycle after an input is accepted until the cycle after its final command is accepted, and then returns high.
- R10: While an output command is valid and not accepted, it stays valid and its fields do not change.
- R11: During and after reset the output valid is low and the input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input command valid |
| s_ready | output | 1 | Input command ready |
| s_addr | input | AW | Input start address |
| s_len | input | 8 | Input beats minus one |
| s_size | input | 3 | Input log2 bytes per beat |
| s_burst | input | 2 | Input burst type (00 FIXED, 01 INCR, 10 WRAP) |
| s_lock | input | 1 | Input lock |
| m_valid | output | 1 | Output command valid |
| m_ready | input | 1 | Output command ready |
| m_addr | output | AW | Output start address |
| m_len | output | 8 | Output beats minus one |
| m_size | output | 3 | Output log2 bytes per beat |
| m_burst | output | 2 | Output burst type |
| m_lock | output | 1 | Output lock |
| m_last | output | 1 | Final command of the current input |

## Verification
The sweep walks every legal size with lengths that cross the 256-beat limit and with start addresses that are unaligned inside the master word and inside the slave word. A design that drops the alignment adjustment gives first-command lengths too long by adj. A design that splits at the wrong boundary puts later commands at addresses that are off by adj words. WRAP bursts are tried at every size-aligned offset inside the wrap window. This catches a two-piece split that swaps the two lengths, a missing wrap-base address, or a burst left as WRAP past 16 beats. FIXED bursts of up to 256 repeats check that the repeat count, the lock clearing, the last flag and the output stall holding are each exact.

// File: rtl/dnz_pkg.sv
package dnz_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    typedef struct packed {
        logic [2:0] size;
        burst_e     burst;
        logic       lock;
    } cmd_attr_t;

endpackage

// File: rtl/dnz_plan.sv
module dnz_plan
    import dnz_pkg::*;
#(
    parameter int AW      = 16,
    parameter int BW      = 11,
    parameter int M_BYTES = 4,
    parameter int LIMIT   = 256
) (
    input  logic [AW-1:0] in_addr,
    input  logic [7:0]    in_len,
    input  logic [2:0]    in_size,
    input  logic [1:0]    in_burst,
    input  logic          in_lock,
    output logic [AW-1:0] seg0_addr,
    output logic [AW-1:0] seg1_addr,
    output logic [BW-1:0] seg0_beats,
    output logic [BW-1:0] seg1_beats,
    output logic [BW-1:0] phase,
    output logic          two_seg,
    output logic [8:0]    reps,
    output cmd_attr_t     attr
);
    localparam int          MSZ   = $clog2(M_BYTES);
    localparam logic [31:0] MMASK = 32'(M_BYTES - 1);

    logic [31:0] a32, size_b, size_m, ratio, adj, conv, bb, bm, off;

    always_comb begin
        a32    = 32'(in_addr);
        size_b = 32'd1 << in_size;
        size_m = size_b - 32'd1;
        ratio  = (32'(in_size) > 32'(MSZ)) ? (32'd1 << (32'(in_size) - 32'(MSZ))) : 32'd1;
        adj    = (a32 & size_m & ~MMASK) >> MSZ;
        conv   = (32'(in_len) + 32'd1) * ratio;
        bb     = (32'(in_len) + 32'd1) << in_size;
        bm     = bb - 32'd1;
        off    = a32 & bm;

        seg0_addr  = in_addr;
        seg1_addr  = in_addr;
        seg0_beats = BW'(conv);
        seg1_beats = '0;
        phase      = '0;
        two_seg    = 1'b0;
        reps       = 9'd1;
        attr.size  = 3'(MSZ);
        attr.burst = BT_INCR;
        attr.lock  = 1'b0;

        if (ratio == 32'd1) begin
            seg0_beats = BW'(32'(in_len) + 32'd1);
            attr.size  = in_size;
            attr.burst = burst_e'(in_burst);
            attr.lock  = in_lock;
        end else begin
            case (burst_e'(in_burst))
                BT_FIXED: begin
                    reps       = 9'(32'(in_len) + 32'd1);
                    seg0_beats = BW'(ratio - adj);
                    phase      = BW'(adj);
                end
                BT_WRAP: begin
                    if (conv <= 32'd16) begin
                        attr.burst = BT_WRAP;
                        attr.lock  = in_lock;
                    end else if (off != 32'd0) begin
                        seg0_beats = BW'((bb - off) >> MSZ);
                        seg1_addr  = AW'(a32 & ~bm);
                        seg1_beats = BW'(off >> MSZ);
                        two_seg    = 1'b1;
                    end
                end
                default: begin
                    seg0_beats = BW'(conv - adj);
                    phase      = BW'(adj);
                    attr.lock  = (conv <= 32'(LIMIT)) & in_lock;
                end
            endcase
        end
    end
endmodule

// File: rtl/dnz_emit.sv
module dnz_emit
    import dnz_pkg::*;
#(
    parameter int AW      = 16,
    parameter int BW      = 11,
    parameter int M_BYTES = 4,
    parameter int LIMIT   = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_seg0_addr,
    input  logic [AW-1:0] ld_seg1_addr,
    input  logic [BW-1:0] ld_seg0_beats,
    input  logic [BW-1:0] ld_seg1_beats,
    input  logic [BW-1:0] ld_phase,
    input  logic          ld_two,
    input  logic [8:0]    ld_reps,
    input  cmd_attr_t     ld_attr,
    input  logic          out_ready,
    output logic          busy,
    output logic [AW-1:0] out_addr,
    output logic [7:0]    out_len,
    output logic          out_last,
    output cmd_attr_t     out_attr
);
    localparam int          MSZ   = $clog2(M_BYTES);
    localparam logic [AW-1:0] AMASK = AW'(M_BYTES - 1);

    logic [AW-1:0] s0_addr, s1_addr, cur_addr;
    logic [BW-1:0] s0_beats, s1_beats, ph, rem, avail, chunk, chunk_m1;
    logic          two, seg_sel, first;
    logic [8:0]    reps_left;
    cmd_attr_t     attr_q;
    logic          seg_done;

    always_comb begin
        avail    = BW'(LIMIT) - (first ? ph : '0);
        chunk    = (rem < avail) ? rem : avail;
        chunk_m1 = chunk - BW'(1);
        seg_done = (rem == chunk);
    end

    assign out_addr = cur_addr;
    assign out_len  = chunk_m1[7:0];
    assign out_attr = attr_q;
    assign out_last = seg_done && (!two || seg_sel) && (reps_left == 9'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            s0_addr   <= '0;
            s1_addr   <= '0;
            s0_beats  <= '0;
            s1_beats  <= '0;
            ph        <= '0;
            two       <= 1'b0;
            seg_sel   <= 1'b0;
            first     <= 1'b0;
            cur_addr  <= '0;
            rem       <= '0;
            reps_left <= '0;
            attr_q    <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            s0_addr   <= ld_seg0_addr;
            s1_addr   <= ld_seg1_addr;
            s0_beats  <= ld_seg0_beats;
            s1_beats  <= ld_seg1_beats;
            ph        <= ld_phase;
            two       <= ld_two;
            attr_q    <= ld_attr;
            seg_sel   <= 1'b0;
            first     <= 1'b1;
            cur_addr  <= ld_seg0_addr;
            rem       <= ld_seg0_beats;
            reps_left <= ld_reps;
        end else if (busy && out_ready) begin
            if (!seg_done) begin
                rem      <= rem - chunk;
                cur_addr <= (cur_addr & ~AMASK) + (AW'(chunk) << MSZ);
                first    <= 1'b0;
            end else if (two && !seg_sel) begin
                seg_sel  <= 1'b1;
                cur_addr <= s1_addr;
                rem      <= s1_beats;
                first    <= 1'b1;
            end else if (reps_left > 9'd1) begin
                reps_left <= reps_left - 9'd1;
                cur_addr  <= s0_addr;
                rem       <= s0_beats;
                first     <= 1'b1;
            end else begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dnz_cmd_split.sv
module dnz_cmd_split
    import dnz_pkg::*;
#(
    parameter int AW      = 16,
    parameter int S_BYTES = 16,
    parameter int M_BYTES = 4,
    parameter bit AXI3    = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [AW-1:0] s_addr,
    input  logic [7:0]    s_len,
    input  logic [2:0]    s_size,
    input  logic [1:0]    s_burst,
    input  logic          s_lock,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [AW-1:0] m_addr,
    output logic [7:0]    m_len,
    output logic [2:0]    m_size,
    output logic [1:0]    m_burst,
    output logic          m_lock,
    output logic          m_last
);
    localparam int LIMIT     = AXI3 ? 16 : 256;
    localparam int RATIO_MAX = (S_BYTES > M_BYTES) ? S_BYTES / M_BYTES : 1;
    localparam int BW        = 9 + $clog2(RATIO_MAX);

    logic [AW-1:0] p_s0_addr, p_s1_addr;
    logic [BW-1:0] p_s0_beats, p_s1_beats, p_phase;
    logic          p_two, busy;
    logic [8:0]    p_reps;
    cmd_attr_t     p_attr, o_attr;

    dnz_plan #(.AW(AW), .BW(BW), .M_BYTES(M_BYTES), .LIMIT(LIMIT)) u_plan (
        .in_addr   (s_addr),
        .in_len    (s_len),
        .in_size   (s_size),
        .in_burst  (s_burst),
        .in_lock   (s_lock),
        .seg0_addr (p_s0_addr),
        .seg1_addr (p_s1_addr),
        .seg0_beats(p_s0_beats),
        .seg1_beats(p_s1_beats),
        .phase     (p_phase),
        .two_seg   (p_two),
        .reps      (p_reps),
        .attr      (p_attr)
    );

    dnz_emit #(.AW(AW), .BW(BW), .M_BYTES(M_BYTES), .LIMIT(LIMIT)) u_emit (
        .clk          (clk),
        .rst          (rst),
        .load         (s_valid && s_ready),
        .ld_seg0_addr (p_s0_addr),
        .ld_seg1_addr (p_s1_addr),
        .ld_seg0_beats(p_s0_beats),
        .ld_seg1_beats(p_s1_beats),
        .ld_phase     (p_phase),
        .ld_two       (p_two),
        .ld_reps      (p_reps),
        .ld_attr      (p_attr),
        .out_ready    (m_ready),
        .busy         (busy),
        .out_addr     (m_addr),
        .out_len      (m_len),
        .out_last     (m_last),
        .out_attr     (o_attr)
    );

    assign s_ready = !busy;
    assign m_valid = busy;
    assign m_size  = o_attr.size;
    assign m_burst = o_attr.burst;
    assign m_lock  = o_attr.lock;
endmodule

// File: rtl/dnz_cmd_split_chk.sv
module dnz_cmd_split_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          s_valid,
    input logic          s_ready,
    input logic          m_valid,
    input logic          m_ready,
    input logic [AW-1:0] m_addr,
    input logic [7:0]    m_len,
    input logic [1:0]    m_burst,
    input logic          m_lock,
    input logic          m_last
);
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!m_valid && s_ready));

    p_accept_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> (m_valid && !s_ready));

    p_final_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> (s_ready && !m_valid));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_len)
                                   && $stable(m_burst) && $stable(m_last)));

    p_split_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_last) |-> !m_lock);

    p_wrap_short_r4: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_burst == 2'b10) |-> (m_len < 8'd16));
endmodule

bind dnz_cmd_split dnz_cmd_split_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_dnz_cmd_split.sv
module test_dnz_cmd_split;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int MB  = 4;
    localparam int MSZ = 2;
    localparam int LIM = 256;

    logic clk = 1'b0;
    logic rst;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          s_valid, s_ready, s_lock, m_valid, m_ready, m_lock, m_last;
    logic [AW-1:0] s_addr, m_addr;
    logic [7:0]    s_len, m_len;
    logic [2:0]    s_size, m_size;
    logic [1:0]    s_burst, m_burst;

    dnz_cmd_split #(.AW(AW), .S_BYTES(16), .M_BYTES(MB), .AXI3(1'b0)) i_dnz_cmd_split (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_len(s_len),
        .s_size(s_size), .s_burst(s_burst), .s_lock(s_lock),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_len(m_len),
        .m_size(m_size), .m_burst(m_burst), .m_lock(m_lock), .m_last(m_last)
    );

    typedef struct {
        int addr; int len; int size; int burst; int lock; int last;
    } exp_t;
    exp_t expq[$];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic push(input int a, input int l, input int sz, input int bt, input int lk);
        exp_t e;
        e.addr = a & 16'hFFFF; e.len = l; e.size = sz; e.burst = bt; e.lock = lk; e.last = 0;
        expq.push_back(e);
    endtask

    task automatic build_ref(input int a, input int len, input int sz, input int bt, input int lk);
        int sb, sm, ratio, adj, dlen, n, bb, bm;
        sb    = 1 << sz;
        sm    = sb - 1;
        ratio = (sz > MSZ) ? (1 << (sz - MSZ)) : 1;
        adj   = (a & sm & ~(MB - 1)) / MB;
        dlen  = (len + 1) * ratio - 1;
        if (ratio == 1) begin
            push(a, len, sz, bt, lk);
        end else if (bt == 0) begin
            for (int r = 0; r <= len; r++) push(a, ratio - adj - 1, MSZ, 1, 0);
        end else if (bt == 2) begin
            if (dlen + 1 <= 16) push(a, dlen, MSZ, 2, lk);
            else begin
                bb = sb * (len + 1);
                bm = bb - 1;
                if ((a & bm) == 0) push(a, dlen, MSZ, 1, 0);
                else begin
                    push(a, (bb - (a & bm)) / MB - 1, MSZ, 1, 0);
                    push(a & ~bm, (a & bm) / MB - 1, MSZ, 1, 0);
                end
            end
        end else begin
            n = (dlen + LIM) / LIM;
            if (n == 1) push(a, dlen - adj, MSZ, 1, lk);
            else begin
                for (int i = 1; i <= n; i++) begin
                    if (i == 1)      push(a, LIM - adj - 1, MSZ, 1, 0);
                    else if (i == n) push((a & ~sm) + (i - 1) * LIM * MB, dlen % LIM, MSZ, 1, 0);
                    else             push((a & ~sm) + (i - 1) * LIM * MB, LIM - 1, MSZ, 1, 0);
                end
            end
        end
        expq[expq.size() - 1].last = 1;
    endtask

    task automatic run_cmd(input int a, input int len, input int sz, input int bt,
                           input int lk, input string tag);
        exp_t e;
        int guard;
        bit stalled;
        logic [AW-1:0] sv_addr;
        logic [7:0] sv_len;
        logic sv_last;
        build_ref(a, len, sz, bt, lk);
        @(negedge clk);
        s_addr = AW'(a); s_len = 8'(len); s_size = 3'(sz); s_burst = 2'(bt); s_lock = lk[0];
        s_valid = 1'b1;
        m_ready = 1'b0;
        @(negedge clk);
        s_valid = 1'b0;
        check(s_ready == 1'b0, "R9", "ready after accept", s_ready, 0);
        guard = 0;
        stalled = 0;
        while (expq.size() > 0 && guard < 4000) begin
            if (stalled) begin
                check(m_valid && m_addr == sv_addr && m_len == sv_len && m_last == sv_last,
                      "R10", "stalled command changed", {m_addr, m_len}, {sv_addr, sv_len});
                stalled = 0;
            end
            cyc++;
            m_ready = (cyc % 3) != 0;
            if (m_valid && m_ready) begin
                e = expq.pop_front();
                check(int'(m_addr) == e.addr && int'(m_len) == e.len && int'(m_burst) == e.burst
                      && int'(m_lock) == e.lock, tag, "addr/len/burst/lock",
                      {m_addr, m_len, m_burst, m_lock}, {e.addr[15:0], e.len[7:0], e.burst[1:0], e.lock[0]});
                check(int'(m_size) == e.size, "R7", "size", m_size, e.size);
                check(int'(m_last) == e.last, "R8", "last flag", m_last, e.last);
            end else if (m_valid) begin
                stalled = 1; sv_addr = m_addr; sv_len = m_len; sv_last = m_last;
            end
            @(negedge clk);
            guard++;
        end
        check(expq.size() == 0, tag, "commands missing", expq.size(), 0);
        expq.delete();
        check(s_ready && !m_valid, "R9", "idle after final command", {s_ready, m_valid}, 2'b10);
        m_ready = 1'b0;
    endtask

    int lens[8] = '{0, 1, 3, 7, 15, 63, 64, 255};
    int offs[6] = '{0, 1, 4, 8, 12, 'h3C};
    int wls[4]  = '{1, 3, 7, 15};

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        report();
    end

    initial begin
        int lk, ratio;
        string tag;
        s_valid = 0; s_addr = '0; s_len = '0; s_size = '0; s_burst = '0; s_lock = 0; m_ready = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!m_valid && s_ready, "R11", "state in reset", {m_valid, s_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        check(!m_valid && s_ready, "R11", "state after reset", {m_valid, s_ready}, 2'b01);
        lk = 0;
        for (int sz = 0; sz <= 4; sz++) begin
            ratio = (sz > MSZ) ? (1 << (sz - MSZ)) : 1;
            for (int li = 0; li < 8; li++) begin
                for (int oi = 0; oi < 6; oi++) begin
                    lk ^= 1;
                    if (ratio == 1) tag = "R1";
                    else if ((lens[li] + 1) * ratio > LIM) tag = "R3";
                    else tag = "R2";
                    run_cmd('h1000 + offs[oi], lens[li], sz, 1, lk, tag);
                    run_cmd('h1000 + offs[oi], lens[li], sz, 0, lk, (ratio == 1) ? "R1" : "R6");
                end
            end
            for (int wi = 0; wi < 4; wi++) begin
                for (int k = 0; k <= wls[wi]; k++) begin
                    if (ratio == 1) tag = "R1";
                    else if ((wls[wi] + 1) * ratio <= 16) tag = "R4";
                    else tag = "R5";
                    run_cmd('h2000 + k * (1 << sz), wls[wi], sz, 2, k & 1, tag);
                end
            end
        end
        // R2: reserved burst code 11 behaves as INCR
        run_cmd('h1008, 5, 4, 3, 1, "R2");
        run_cmd('h100C, 70, 4, 3, 0, "R3");
        report();
    end
endmodule